// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a two-wire bus slave in front of a 2048-byte memory that is held in a synthesizable register array. It filters the clock and data lines, detects bus START and STOP conditions, and checks the device-select byte. It then runs write and read transfers on an 11-bit address. The data line is open-drain, so the block drives it only through a pull-low enable. The bench models the wired-AND bus.

Written bytes are collected in a 16-entry page staging buffer. They reach the array only after a STOP, during an internal write cycle of `WR_CYC` clocks. For that whole cycle the block ignores the bus, so a host can poll for completion. Reads use one address counter that runs across the whole array. A write-protect input blocks commits. A reset-active input from the system supervisor makes the block ignore the bus entirely.

Top module: `i2c_mem_slave`

## Requirements
- R1: The device-select byte is sent MSB first. Bits [7:4] must equal 4'b1010, bits [3:1] carry address bits 10..8, and bit 0 selects the direction (1 = read, 0 = write). On a match the block pulls SDA low for the ninth clock; on any other value bits [7:4] it leaves SDA released.
- R2: After a write header is acknowledged, the next byte loads address bits 7..0 and is acknowledged. The header's bits [3:1] load address bits 10..8.
- R3: Every data byte of a write is acknowledged and staged at the current address. After each byte only address bits 3..0 increment, so a 16-byte page wraps onto itself and later bytes overwrite earlier ones.
- R4: Staged bytes are written to the array only after a STOP. A START that arrives before the STOP discards them, and no write cycle follows.
- R5: From the STOP that starts a commit until `WR_CYC` clocks have passed, no device-select byte is acknowledged. After that, a header is acknowledged again and the committed data can be read back.
- R6: A read header starts at the current address counter, which is the last accessed address plus one. The header's bits [3:1] are ignored.
- R7: Each transmitted byte advances the address across all 11 bits, and the counter wraps from 2047 to 0.
- R8: A random read is a write header and an address byte, followed by a repeated START and a read header. It returns the byte at that address.
- R9: When the host does not acknowledge a read byte, the block releases SDA and stays silent until the next START or STOP.
- R10: While `wp_i` is high at STOP, data bytes are still acknowledged, but nothing is written and no write cycle runs.
- R11: While `sup_rst_i` is high, the block acknowledges nothing. A pulse of it in the middle of a write discards the staged bytes.
- R12: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` clocks is ignored.
- R13: During and straight after reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, raw |
| sda_i | input | 1 | Bus data line as seen on the wire, raw |
| wp_i | input | 1 | Write protect; blocks the commit |
| sup_rst_i | input | 1 | Reset-active flag from the supervisor, synchronous to clk_i |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data line |

## Verification
The assertions assume that `sup_rst_i` and `wp_i` are synchronous to the clock. They also assume the host changes SDA only while SCL is low, except when it forms START and STOP, so any pull-low change falls inside the low phase of the filtered clock. The bench master holds each bus phase for ten clocks, which is longer than the filter and synchronizer delay. It changes data only in the middle of the low phase. Its deliberate glitches last two clocks at most, against a filter length of four.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} bus_st_e;
  typedef enum logic [1:0] {K_DEV, K_ADDR, K_DATA} rx_kind_e;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int   FILT_CYC = 4,
  parameter logic INIT     = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  // output follows only after FILT_CYC consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {2{INIT}};
      line_o <= INIT;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          line_o <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/byte_mem.sv
module byte_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/page_stage.sv
module page_stage #(
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 11,
  parameter int WR_CYC     = 256,
  localparam int PW        = $clog2(PAGE_BYTES),
  localparam int BW        = ADDR_W - PW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_we_i,
  input  logic [PW-1:0]     st_idx_i,
  input  logic [7:0]        st_data_i,
  input  logic              clear_i,
  input  logic              go_i,
  input  logic [BW-1:0]     base_i,
  output logic              busy_o,
  output logic              has_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  localparam int CW = $clog2(WR_CYC + 1);

  logic [7:0]            stage_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [BW-1:0]         base_q;
  logic [CW-1:0]         cyc_q;
  logic                  busy_q;

  always_ff @(posedge clk_i) begin
    if (st_we_i) stage_q[st_idx_i] <= st_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      base_q <= '0;
      cyc_q  <= '0;
      busy_q <= 1'b0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      cyc_q  <= '0;
      base_q <= base_i;
    end else if (busy_q) begin
      if (cyc_q == CW'(WR_CYC - 1)) begin
        busy_q <= 1'b0;
        vld_q  <= '0;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end else if (clear_i) begin
      vld_q <= '0;
    end else if (st_we_i) begin
      vld_q[st_idx_i] <= 1'b1;
    end
  end

  // one staged byte per clock during the first PAGE_BYTES cycles of the commit
  assign mem_we_o   = busy_q && (cyc_q < CW'(PAGE_BYTES)) && vld_q[cyc_q[PW-1:0]];
  assign mem_addr_o = {base_q, cyc_q[PW-1:0]};
  assign mem_data_o = stage_q[cyc_q[PW-1:0]];
  assign busy_o     = busy_q;
  assign has_o      = |vld_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 16,
  parameter int FILT_CYC   = 4,
  parameter int WR_CYC     = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  input  logic sup_rst_i,
  output logic sda_pull_o
);
  import i2c_mem_pkg::*;

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HB = AW - 8;

  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    line_filter #(.FILT_CYC(FILT_CYC), .INIT(1'b1)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  bus_st_e       st_q;
  rx_kind_e      kind_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic [AW-1:0] addr_q;
  logic          mack_q, pull_q;

  logic          busy, has_data, mem_we, st_we, go, clear, dev_hit;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata, rd_data;

  assign dev_hit = (sh_q[7:4] == DEV_CODE) && !busy;
  assign st_we   = !sup_rst_i && (st_q == ST_RX) && (kind_q == K_DATA) && scl_fall && (cnt_q == 4'd8);
  assign go      = stop_c && has_data && !wp_i && !busy && !sup_rst_i;
  assign clear   = start_c | stop_c | sup_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      mack_q <= 1'b0;
      pull_q <= 1'b0;
    end else if (sup_rst_i) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
    end else if (start_c) begin
      st_q   <= ST_RX;
      kind_q <= K_DEV;
      cnt_q  <= '0;
      pull_q <= 1'b0;
    end else if (stop_c) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            if (cnt_q < 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (cnt_q == 4'd8) begin
              cnt_q <= 4'd9;
            end
          end else if (scl_fall && cnt_q == 4'd8) begin
            unique case (kind_q)
              K_DEV: begin
                pull_q <= dev_hit;
                if (dev_hit && !sh_q[0]) addr_q[AW-1:8] <= sh_q[HB:1];
              end
              K_ADDR: begin
                pull_q      <= 1'b1;
                addr_q[7:0] <= sh_q;
              end
              default: begin
                pull_q         <= 1'b1;
                addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
              end
            endcase
          end else if (scl_fall && cnt_q == 4'd9) begin
            cnt_q  <= '0;
            pull_q <= 1'b0;
            if (!pull_q) begin
              st_q <= ST_IDLE;
            end else if (kind_q == K_DEV) begin
              if (sh_q[0]) begin
                st_q   <= ST_TX;
                sh_q   <= rd_data;
                pull_q <= ~rd_data[7];
              end else begin
                kind_q <= K_ADDR;
              end
            end else begin
              kind_q <= K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            if (cnt_q < 4'd8) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (cnt_q == 4'd8) begin
              mack_q <= ~sda_f;
              cnt_q  <= 4'd9;
            end
          end else if (scl_fall) begin
            if (cnt_q >= 4'd1 && cnt_q <= 4'd7) begin
              sh_q   <= {sh_q[6:0], 1'b0};
              pull_q <= ~sh_q[6];
            end else if (cnt_q == 4'd8) begin
              pull_q <= 1'b0;
              addr_q <= addr_q + 1'b1;
            end else if (cnt_q == 4'd9) begin
              if (mack_q) begin
                sh_q   <= rd_data;
                pull_q <= ~rd_data[7];
                cnt_q  <= '0;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  page_stage #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(AW), .WR_CYC(WR_CYC)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_we_i   (st_we),
    .st_idx_i  (addr_q[PW-1:0]),
    .st_data_i (sh_q),
    .clear_i   (clear),
    .go_i      (go),
    .base_i    (addr_q[AW-1:PW]),
    .busy_o    (busy),
    .has_o     (has_data),
    .mem_we_o  (mem_we),
    .mem_addr_o(mem_waddr),
    .mem_data_o(mem_wdata)
  );

  byte_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(addr_q),
    .rdata_o(rd_data)
  );

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int HI_W = 7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sup_rst_i,
  input logic            wp_i,
  input logic            sda_pull_o,
  input logic            busy,
  input logic            mem_we,
  input logic            st_we,
  input logic [HI_W-1:0] addr_hi
);
  // R11: one clock after reset-active, SDA is released
  a_r11_rst_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sup_rst_i) |-> !sda_pull_o);

  // R5: no acknowledge of any kind during the internal write cycle
  a_r5_busy_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_pull_o);

  // R5: the array changes only inside a write cycle
  a_r5_write_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy);

  // R10: a commit never starts with write protect high at the STOP
  a_r10_wp_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !$past(wp_i));

  // R3: staging a byte never moves the page base
  a_r3_page_high_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we |=> $stable(addr_hi));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.HI_W(AW - PW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sup_rst_i (sup_rst_i),
  .wp_i      (wp_i),
  .sda_pull_o(sda_pull_o),
  .busy      (busy),
  .mem_we    (mem_we),
  .st_we     (st_we),
  .addr_hi   (addr_q[AW-1:PW])
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int WR_CYC     = 1500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0, sup_rst = 1'b0;
  logic sda_pull, sda_bus;
  logic glitch_en = 1'b0;
  logic done = 1'b0;
  int   n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  i2c_mem_slave #(.MEM_BYTES(2048), .PAGE_BYTES(16), .FILT_CYC(4), .WR_CYC(WR_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .wp_i(wp), .sup_rst_i(sup_rst), .sda_pull_o(sda_pull)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + ((a >> 8) * 11) + 5);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    waitn(Q);
    if (glitch_en) begin
      scl_m = 1'b1; waitn(2); scl_m = 1'b0; waitn(Q);
    end
    sda_m = b;
    waitn(Q);
    scl_m = 1'b1;
    waitn(Q / 2);
    if (glitch_en && b) begin
      sda_m = 1'b0; waitn(1); sda_m = 1'b1;
    end
    waitn(Q / 2);
    s = sda_bus;
    waitn(Q);
    scl_m = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; waitn(Q);
    scl_m = 1'b1; waitn(Q);
    sda_m = 1'b0; waitn(Q);
    scl_m = 1'b0;
  endtask

  task automatic do_stop();
    sda_m = 1'b0; waitn(Q);
    scl_m = 1'b1; waitn(Q);
    sda_m = 1'b1; waitn(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      d = {d[6:0], s};
    end
    bit_io(~mack, s);
  endtask

  task automatic poll(output int n, output logic ack);
    n = 0;
    ack = 1'b0;
    while (!ack && n < 30) begin
      do_start();
      wr_byte(8'hA0, ack);
      do_stop();
      n++;
    end
  endtask

  // write header, address byte, repeated START and read header
  task automatic set_rd(input int a, input string tag);
    logic ack;
    do_start();
    wr_byte({4'hA, 3'(a >> 8), 1'b0}, ack); chk(ack, tag, ack, 1);
    wr_byte(8'(a), ack);                     chk(ack, tag, ack, 1);
    do_start();
    wr_byte(8'hA1, ack);                     chk(ack, tag, ack, 1);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int n;
    logic [7:0] exp_pg [16];

    waitn(5);
    chk(sda_pull == 1'b0, "R13 pull in reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    waitn(20);
    chk(sda_pull == 1'b0, "R13 pull after reset", int'(sda_pull), 0);

    // R1: wrong device code
    do_start(); wr_byte(8'hB0, ack); do_stop();
    chk(!ack, "R1 foreign code ack", ack, 0);

    // page write at 0x000 and poll during the write cycle
    do_start();
    wr_byte(8'hA0, ack); chk(ack, "R1 header ack", ack, 1);
    wr_byte(8'h00, ack); chk(ack, "R2 address ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      wr_byte(pat(i), ack); chk(ack, "R3 data ack", ack, 1);
    end
    do_stop();
    poll(n, ack);
    chk(n >= 2, "R5 first poll during write cycle acked", n, 2);
    chk(ack, "R5 ack after write cycle", ack, 1);

    // page write at 0x7F0, block bits in header
    do_start();
    wr_byte(8'hAE, ack); chk(ack, "R2 block header ack", ack, 1);
    wr_byte(8'hF0, ack); chk(ack, "R2 address ack", ack, 1);
    for (int i = 0; i < 16; i++) wr_byte(pat(16'h7F0 + i), ack);
    do_stop();
    poll(n, ack);
    chk(ack, "R5 ack after second cycle", ack, 1);

    // R8 random read of whole page 0x7F0
    set_rd(16'h7F0, "R8 setup");
    for (int i = 0; i < 16; i++) begin
      rd_byte(i != 15, d);
      chk(d == pat(16'h7F0 + i), "R8 random read", d, pat(16'h7F0 + i));
    end
    do_stop();

    // R7 wrap from 2047 to 0, then R9 silence after NACK
    set_rd(16'h7FC, "R7 setup");
    for (int i = 0; i < 6; i++) begin
      rd_byte(i != 5, d);
      chk(d == pat((16'h7FC + i) % 2048), "R7 sequential wrap", d, pat((16'h7FC + i) % 2048));
    end
    rd_byte(1'b0, d);
    chk(d == 8'hFF, "R9 released after NACK", d, 8'hFF);
    do_stop();

    // R6 current address read, header block bits ignored
    do_start();
    wr_byte(8'hA5, ack); chk(ack, "R6 read header ack", ack, 1);
    rd_byte(1'b0, d);
    chk(d == pat(2), "R6 current address", d, pat(2));
    do_stop();

    // R3 page wrap: 18 bytes from 0x012
    do_start();
    wr_byte(8'hA0, ack);
    wr_byte(8'h12, ack);
    for (int k = 0; k < 18; k++) begin
      wr_byte(8'hC0 + 8'(k), ack); chk(ack, "R3 wrap data ack", ack, 1);
      exp_pg[(2 + k) % 16] = 8'hC0 + 8'(k);
    end
    do_stop();
    poll(n, ack);
    set_rd(16'h00F, "R3 setup");
    rd_byte(1'b1, d);
    chk(d == pat(15), "R3 neighbour page untouched", d, pat(15));
    for (int o = 0; o < 16; o++) begin
      rd_byte(o != 15, d);
      chk(d == exp_pg[o], "R3 page wrap overwrite", d, exp_pg[o]);
    end
    do_stop();

    // R10 write protect
    wp = 1'b1;
    do_start();
    wr_byte(8'hA0, ack); wr_byte(8'h05, ack);
    wr_byte(8'h5A, ack); chk(ack, "R10 data acked under protect", ack, 1);
    do_stop();
    set_rd(16'h005, "R10 no write cycle");
    rd_byte(1'b0, d);
    chk(d == pat(5), "R10 location unchanged", d, pat(5));
    do_stop();
    wp = 1'b0;

    // R4 repeated START discards staged byte
    do_start();
    wr_byte(8'hA0, ack); wr_byte(8'h08, ack); wr_byte(8'hEE, ack);
    do_start();
    wr_byte(8'hA1, ack); chk(ack, "R4 read header after abort", ack, 1);
    rd_byte(1'b0, d);
    chk(d == pat(9), "R4 current address after staged byte", d, pat(9));
    do_stop();
    set_rd(16'h008, "R4 no write cycle");
    rd_byte(1'b0, d);
    chk(d == pat(8), "R4 aborted write not committed", d, pat(8));
    do_stop();

    // R11 reset-active
    sup_rst = 1'b1;
    do_start(); wr_byte(8'hA0, ack); do_stop();
    chk(!ack, "R11 no ack while reset active", ack, 0);
    sup_rst = 1'b0;
    do_start();
    wr_byte(8'hA0, ack); wr_byte(8'h03, ack); wr_byte(8'h77, ack);
    sup_rst = 1'b1; waitn(3); sup_rst = 1'b0;
    do_stop();
    set_rd(16'h003, "R11 no write cycle");
    rd_byte(1'b0, d);
    chk(d == pat(3), "R11 staged byte discarded", d, pat(3));
    do_stop();

    // R12 short pulses on both lines
    glitch_en = 1'b1;
    do_start();
    wr_byte(8'hA0, ack); chk(ack, "R12 header with glitches", ack, 1);
    wr_byte(8'h06, ack); chk(ack, "R12 address with glitches", ack, 1);
    wr_byte(8'h3C, ack); chk(ack, "R12 data with glitches", ack, 1);
    glitch_en = 1'b0;
    do_stop();
    poll(n, ack);
    chk(ack, "R12 write cycle completes", ack, 1);
    set_rd(16'h006, "R12 setup");
    rd_byte(1'b0, d);
    chk(d == 8'h3C, "R12 glitched write data", d, 8'h3C);
    do_stop();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule